// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the configuration and status registers of a small SDRAM controller. Software reaches it through two device-control ports. The index port (port 0x10) stores the offset of an internal register. The data port (port 0x11) then reads or writes the register that the stored offset selects. The block keeps two error status words, an error address, the global configuration word, a read-only status word, refresh, power-management and timing values, the ECC configuration and ECC error status, and one control word for each memory bank. Each register has its own write mask, and some have forced bits.

The block also decodes bank hits for downstream logic. A physical address on `probe_addr` hits a bank when the controller is on, the bank's enable bit is set, and the address matches that bank's base over the bank's size. Two things are outputs of the block: the one-hot bank hit vector, and an interrupt that stays high while the ECC error status is nonzero.

Controller enable is tracked by a two-state machine. `CTL_OFF` is the state after reset. `CTL_ON` is the running state. The transition EN_RISE (`CTL_OFF` to `CTL_ON`) happens when a configuration write sets bit 31, and it clears status bit 31. The transition EN_FALL (`CTL_ON` to `CTL_OFF`) happens when a configuration write clears bit 31, and it sets status bit 31. Any other configuration write leaves the state where it is.

Top module: `sdram_cfg_regs`

## Requirements
- R1: A write on port 0x10 stores the full 32-bit index, and a read on port 0x10 returns it. Accesses on port 0x11 go to the internal register at that index. All register effects appear on the clock edge that samples the write.
- R2: The error status words at offsets 0x00 and 0x08 clear each bit that is written as 1. No write can set a bit, so both read 0 after any write. Offset 0x10 stores and returns the whole written word.
- R3: A configuration write (offset 0x20) keeps only the bits under mask 0xFFE00000.
- R4: A configuration write that sets bit 31 while the controller is off turns the controller on and clears status bit 31. A write that clears bit 31 while the controller is on turns it off and sets status bit 31.
- R5: A configuration write where bit 30 goes from 0 to 1 sets status bit 30. A write where it goes from 1 to 0 clears status bit 30.
- R6: Writes to the status word (offset 0x24) have no effect.
- R7: Refresh (0x30) keeps mask 0x3FF80000. The power word (0x34) stores (value AND 0xF8000000) OR 0x07C00000. Timing (0x80) keeps mask 0x018FC01F. ECC configuration (0x94) keeps mask 0x00F00000.
- R8: ECC error status (0x98) keeps mask 0xFFF0F000. `ecc_irq` is high exactly while the stored value is nonzero.
- R9: Bank words sit at offset 0x40 + 4*n and keep mask 0xFFDEE001. In each bank word:
  - bit 0 is the enable;
  - bits 31:23 are the base;
  - bits 19:17 are a size code c, giving a size of 4 MiB << c.
- R10: `bank_hit[n]` can be high only while the controller is on, bank n is enabled and its code is not 7. The address must match the base on every bit at or above log2 of the bank size, within bits 31:23.
- R11: `bank_hit` is one-hot or zero. When several banks match, only the lowest-numbered one is reported.
- R12: Reset values:
  - refresh 0x05F00000;
  - power word 0x07C00000;
  - timing 0x00854009;
  - configuration 0x00800000;
  - every other register and the index are 0.
- R13: A data-port read of an undefined offset returns 0xFFFFFFFF. Reads on any other port return 0, and writes on other ports change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 10 | Device-control port number |
| wr_en | input | 1 | Write strobe for the selected port |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the selected port, combinational |
| probe_addr | input | 32 | Physical address to decode against the banks |
| bank_hit | output | 4 | One-hot bank hit |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
A wrong enable state shows up in two places: in the status flags read back through the data port, and at once on `bank_hit`, which must go to zero in the cycle after a disabling write. A wrong mask or a lost forced bit is visible on the first read-back after the write, because every register is compared against a reference model after each random write. A broken bank size or priority decode shows on `bank_hit` in the same cycle the probe address is presented. The probes are biased onto configured bank bases, so that hits and overlaps happen often.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
    localparam int DW = 32;

    typedef enum logic {
        CTL_OFF = 1'b0,
        CTL_ON  = 1'b1
    } ctl_state_e;

    localparam logic [DW-1:0] OFF_ERR0  = 32'h00;
    localparam logic [DW-1:0] OFF_ERR1  = 32'h08;
    localparam logic [DW-1:0] OFF_EADDR = 32'h10;
    localparam logic [DW-1:0] OFF_CFG   = 32'h20;
    localparam logic [DW-1:0] OFF_STAT  = 32'h24;
    localparam logic [DW-1:0] OFF_RFSH  = 32'h30;
    localparam logic [DW-1:0] OFF_PWR   = 32'h34;
    localparam logic [DW-1:0] OFF_BANK0 = 32'h40;
    localparam logic [DW-1:0] OFF_TIM   = 32'h80;
    localparam logic [DW-1:0] OFF_ECFG  = 32'h94;
    localparam logic [DW-1:0] OFF_ESTAT = 32'h98;

    localparam logic [DW-1:0] MSK_CFG   = 32'hFFE0_0000;
    localparam logic [DW-1:0] MSK_RFSH  = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_PWR   = 32'hF800_0000;
    localparam logic [DW-1:0] FRC_PWR   = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_TIM   = 32'h018F_C01F;
    localparam logic [DW-1:0] MSK_ECFG  = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_ESTAT = 32'hFFF0_F000;
    localparam logic [DW-1:0] MSK_BANK  = 32'hFFDE_E001;
    localparam logic [DW-1:0] MSK_BASE  = 32'hFF80_0000;
    localparam logic [DW-1:0] MIN_SIZE  = 32'h0040_0000;

    localparam logic [DW-1:0] RST_RFSH  = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_PWR   = 32'h07C0_0000;
    localparam logic [DW-1:0] RST_TIM   = 32'h0085_4009;
    localparam logic [DW-1:0] RST_CFG   = 32'h0080_0000;
endpackage

// File: rtl/sdram_cfg_ctl.sv
module sdram_cfg_ctl
    import sdram_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_new,   // written bits 31:30
    input  logic       cfg_old30, // stored bit 30 before the write
    output logic       ctl_on,
    output logic [1:0] stat_q     // status bits 31:30
);
    ctl_state_e state_q, state_d;
    logic       go_on, go_off;

    always_comb begin
        state_d = state_q;
        go_on   = 1'b0;
        go_off  = 1'b0;
        unique case (state_q)
            CTL_OFF: if (cfg_wr && cfg_new[1]) begin
                state_d = CTL_ON;   // EN_RISE
                go_on   = 1'b1;
            end
            CTL_ON: if (cfg_wr && !cfg_new[1]) begin
                state_d = CTL_OFF;  // EN_FALL
                go_off  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 2'b00;
        end else begin
            if (go_on)  stat_q[1] <= 1'b0;
            if (go_off) stat_q[1] <= 1'b1;
            if (cfg_wr && !cfg_old30 && cfg_new[0]) stat_q[0] <= 1'b1;
            if (cfg_wr && cfg_old30 && !cfg_new[0]) stat_q[0] <= 1'b0;
        end
    end

    assign ctl_on = (state_q == CTL_ON);

    p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_new[1] && !ctl_on) |=> (ctl_on && !stat_q[1]));
    p_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_new[1] && ctl_on) |=> (!ctl_on && stat_q[1]));
    p_mirror30_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_old30 && cfg_new[0]) |=> stat_q[0]);
endmodule

// File: rtl/sdram_cfg_bank_dec.sv
module sdram_cfg_bank_dec
    import sdram_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_on,
    input  logic [NUM_BANKS-1:0][DW-1:0]  bank_q,
    input  logic [DW-1:0]                 probe_addr,
    output logic [NUM_BANKS-1:0]          hit
);
    logic [NUM_BANKS-1:0] raw;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [2:0]    code;
        logic [DW-1:0] region_msk;
        assign code       = bank_q[g][19:17];
        assign region_msk = MSK_BASE & ~((MIN_SIZE << code) - 32'd1);
        assign raw[g] = ctl_on && bank_q[g][0] && (code != 3'd7) &&
                        (((probe_addr ^ bank_q[g]) & region_msk) == '0);
    end

    always_comb begin
        hit = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (raw[i] && hit == '0) hit[i] = 1'b1;
    end

    p_hit_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    p_no_hit_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_on |-> (hit == '0));
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int               NUM_BANKS = 4,
    parameter int               PORT_W    = 10,
    parameter logic [PORT_W-1:0] IDX_PORT = 10'h010,
    parameter logic [PORT_W-1:0] DAT_PORT = 10'h011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_W-1:0]    port_addr,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    input  logic [DW-1:0]        probe_addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic                 ecc_irq
);
    logic [DW-1:0] index_q, err0_q, err1_q, eaddr_q, cfg_q;
    logic [DW-1:0] rfsh_q, pwr_q, tim_q, ecfg_q, estat_q, data_rd;
    logic [NUM_BANKS-1:0][DW-1:0] bank_q;
    logic [1:0] stat_q;
    logic       ctl_on, idx_wr, dat_wr, cfg_wr;

    assign idx_wr = wr_en && (port_addr == IDX_PORT);
    assign dat_wr = wr_en && (port_addr == DAT_PORT);
    assign cfg_wr = dat_wr && (index_q == OFF_CFG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0; err0_q <= '0; err1_q <= '0; eaddr_q <= '0;
            cfg_q   <= RST_CFG; rfsh_q <= RST_RFSH; pwr_q <= RST_PWR;
            tim_q   <= RST_TIM; ecfg_q <= '0; estat_q <= '0;
            bank_q  <= '0;
        end else begin
            if (idx_wr) index_q <= wr_data;
            if (dat_wr) begin
                case (index_q)
                    OFF_ERR0:  err0_q  <= err0_q & ~wr_data;
                    OFF_ERR1:  err1_q  <= err1_q & ~wr_data;
                    OFF_EADDR: eaddr_q <= wr_data;
                    OFF_CFG:   cfg_q   <= wr_data & MSK_CFG;
                    OFF_RFSH:  rfsh_q  <= wr_data & MSK_RFSH;
                    OFF_PWR:   pwr_q   <= (wr_data & MSK_PWR) | FRC_PWR;
                    OFF_TIM:   tim_q   <= wr_data & MSK_TIM;
                    OFF_ECFG:  ecfg_q  <= wr_data & MSK_ECFG;
                    OFF_ESTAT: estat_q <= wr_data & MSK_ESTAT;
                    default: ;
                endcase
                for (int i = 0; i < NUM_BANKS; i++)
                    if (index_q == OFF_BANK0 + DW'(4 * i))
                        bank_q[i] <= wr_data & MSK_BANK;
            end
        end
    end

    always_comb begin
        case (index_q)
            OFF_ERR0:  data_rd = err0_q;
            OFF_ERR1:  data_rd = err1_q;
            OFF_EADDR: data_rd = eaddr_q;
            OFF_CFG:   data_rd = cfg_q;
            OFF_STAT:  data_rd = {stat_q, 30'd0};
            OFF_RFSH:  data_rd = rfsh_q;
            OFF_PWR:   data_rd = pwr_q;
            OFF_TIM:   data_rd = tim_q;
            OFF_ECFG:  data_rd = ecfg_q;
            OFF_ESTAT: data_rd = estat_q;
            default:   data_rd = '1;
        endcase
        for (int i = 0; i < NUM_BANKS; i++)
            if (index_q == OFF_BANK0 + DW'(4 * i)) data_rd = bank_q[i];
    end

    assign rd_data = (port_addr == IDX_PORT) ? index_q :
                     (port_addr == DAT_PORT) ? data_rd : '0;
    assign ecc_irq = |estat_q;

    sdram_cfg_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_new   (wr_data[31:30]),
        .cfg_old30 (cfg_q[30]),
        .ctl_on    (ctl_on),
        .stat_q    (stat_q)
    );

    sdram_cfg_bank_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_on     (ctl_on),
        .bank_q     (bank_q),
        .probe_addr (probe_addr),
        .hit        (bank_hit)
    );

    p_idx_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (index_q == $past(wr_data)));
    p_status_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && index_q == OFF_STAT) |=> $stable(stat_q));
    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && index_q == OFF_ESTAT && (wr_data & MSK_ESTAT) != '0) |=> ecc_irq);
    p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && index_q == OFF_ESTAT && (wr_data & MSK_ESTAT) == '0) |=> !ecc_irq);
    p_enable_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_on == cfg_q[31]);
endmodule

// File: tb/sdram_cfg_regs_test.sv
module sdram_cfg_regs_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  port_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] probe_addr = '0;
    logic [3:0]  bank_hit;
    logic        ecc_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    sdram_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .probe_addr(probe_addr),
        .bank_hit(bank_hit), .ecc_irq(ecc_irq)
    );

    // reference model state
    logic [31:0] m_idx, m_err0, m_err1, m_eaddr, m_cfg, m_stat, m_rfsh;
    logic [31:0] m_pwr, m_tim, m_ecfg, m_estat;
    logic [31:0] m_bank [4];

    function automatic void model_reset();
        m_idx = 0; m_err0 = 0; m_err1 = 0; m_eaddr = 0; m_cfg = 32'h0080_0000;
        m_stat = 0; m_rfsh = 32'h05F0_0000; m_pwr = 32'h07C0_0000;
        m_tim = 32'h0085_4009; m_ecfg = 0; m_estat = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endfunction

    function automatic void model_write(logic [31:0] off, logic [31:0] v);
        logic [31:0] nv;
        case (off)
            32'h00: m_err0 &= ~v;
            32'h08: m_err1 &= ~v;
            32'h10: m_eaddr = v;
            32'h20: begin
                nv = v & 32'hFFE0_0000;
                if (!m_cfg[31] && nv[31]) m_stat[31] = 1'b0;
                else if (m_cfg[31] && !nv[31]) m_stat[31] = 1'b1;
                if (!m_cfg[30] && nv[30]) m_stat[30] = 1'b1;
                else if (m_cfg[30] && !nv[30]) m_stat[30] = 1'b0;
                m_cfg = nv;
            end
            32'h30: m_rfsh = v & 32'h3FF8_0000;
            32'h34: m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
            32'h40: m_bank[0] = v & 32'hFFDE_E001;
            32'h44: m_bank[1] = v & 32'hFFDE_E001;
            32'h48: m_bank[2] = v & 32'hFFDE_E001;
            32'h4C: m_bank[3] = v & 32'hFFDE_E001;
            32'h80: m_tim = v & 32'h018F_C01F;
            32'h94: m_ecfg = v & 32'h00F0_0000;
            32'h98: m_estat = v & 32'hFFF0_F000;
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] model_read(logic [31:0] off);
        case (off)
            32'h00: return m_err0;
            32'h08: return m_err1;
            32'h10: return m_eaddr;
            32'h20: return m_cfg;
            32'h24: return m_stat;
            32'h30: return m_rfsh;
            32'h34: return m_pwr;
            32'h40: return m_bank[0];
            32'h44: return m_bank[1];
            32'h48: return m_bank[2];
            32'h4C: return m_bank[3];
            32'h80: return m_tim;
            32'h94: return m_ecfg;
            32'h98: return m_estat;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [3:0] model_hit(logic [31:0] a);
        logic [31:0] msk;
        logic [2:0]  c;
        if (!m_cfg[31]) return 4'b0;
        for (int i = 0; i < 4; i++) begin
            c = m_bank[i][19:17];
            msk = 32'hFF80_0000 & ~((32'h0040_0000 << c) - 32'd1);
            if (m_bank[i][0] && c != 3'd7 && ((a ^ m_bank[i]) & msk) == 0)
                return 4'b0001 << i;
        end
        return 4'b0;
    endfunction

    function automatic logic [31:0] pick_off(int unsigned n);
        case (n % 17)
            0: return 32'h00;  1: return 32'h08;  2: return 32'h10;
            3: return 32'h20;  4: return 32'h24;  5: return 32'h30;
            6: return 32'h34;  7: return 32'h40;  8: return 32'h44;
            9: return 32'h48;  10: return 32'h4C; 11: return 32'h80;
            12: return 32'h94; 13: return 32'h98; 14: return 32'h04;
            15: return 32'h50; default: return 32'h20;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic port_wr(logic [9:0] p, logic [31:0] v);
        @(negedge clk);
        port_addr = p; wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_wr(logic [31:0] off, logic [31:0] v);
        port_wr(10'h010, off); m_idx = off;
        port_wr(10'h011, v);   model_write(off, v);
    endtask

    task automatic reg_chk(string tag, logic [31:0] off);
        port_wr(10'h010, off); m_idx = off;
        port_addr = 10'h011; #1;
        check(tag, rd_data, model_read(off));
    endtask

    task automatic hit_chk(string tag, logic [31:0] a);
        probe_addr = a; #1;
        check(tag, {28'd0, bank_hit}, {28'd0, model_hit(a)});
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        logic [31:0] off, v, a;
        r = $urandom(32'd4242);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset values
        port_addr = 10'h010; #1;
        check("R12 index reset", rd_data, 32'h0);
        check("R12 irq reset", {31'd0, ecc_irq}, 32'd0);
        for (int k = 0; k < 14; k++) reg_chk("R12 reset value", pick_off(k));
        // R1 index read back
        port_wr(10'h010, 32'hDEAD_0123); port_addr = 10'h010; #1;
        check("R1 index readback", rd_data, 32'hDEAD_0123);
        // R13 undefined offset and foreign port
        reg_chk("R13 undefined offset", 32'h0000_00FC);
        port_wr(10'h012, 32'h0000_0020); port_addr = 10'h012; #1;
        check("R13 foreign port read", rd_data, 32'h0);
        port_addr = 10'h010; #1;
        check("R13 foreign write ignored", rd_data, 32'h0000_00FC);
        // R2
        reg_wr(32'h00, 32'hFFFF_FFFF); reg_chk("R2 err0 w1c", 32'h00);
        reg_wr(32'h08, 32'hFFFF_FFFF); reg_chk("R2 err1 w1c", 32'h08);
        reg_wr(32'h10, 32'h1234_5678); reg_chk("R2 error address", 32'h10);
        // R3 R4 R5
        reg_wr(32'h20, 32'hFFFF_FFFF); reg_chk("R3 cfg mask", 32'h20);
        reg_chk("R4 R5 status after enable", 32'h24);
        reg_wr(32'h24, 32'h0000_0000); reg_chk("R6 status read-only", 32'h24);
        // R9 R10 R11 banks
        reg_wr(32'h40, 32'h1004_0001); reg_chk("R9 bank0 value", 32'h40);
        reg_wr(32'h44, 32'h1000_0001); // 4 MiB overlapping bank0
        reg_wr(32'h48, 32'h200E_0001); // code 7
        reg_wr(32'h4C, 32'hFFFF_FFFF); reg_chk("R9 bank3 mask", 32'h4C);
        hit_chk("R10 bank0 top", 32'h10FF_FFFF);
        check("R10 bank0 literal", {28'd0, bank_hit}, 32'h1);
        hit_chk("R10 past bank0", 32'h1100_0000);
        hit_chk("R10 code 7 invalid", 32'h2000_0000);
        hit_chk("R11 overlap lowest", 32'h1000_0000);
        reg_wr(32'h20, 32'h4000_0000);
        reg_chk("R4 status after disable", 32'h24);
        hit_chk("R10 no hit when off", 32'h1000_0000);
        check("R10 off literal", {28'd0, bank_hit}, 32'h0);
        reg_wr(32'h20, 32'h0000_0000); reg_chk("R5 bit30 falls", 32'h24);
        // R7 R8
        reg_wr(32'h30, 32'hFFFF_FFFF); reg_chk("R7 refresh", 32'h30);
        reg_wr(32'h34, 32'h0000_0000); reg_chk("R7 power forced", 32'h34);
        reg_wr(32'h80, 32'hFFFF_FFFF); reg_chk("R7 timing", 32'h80);
        reg_wr(32'h94, 32'hFFFF_FFFF); reg_chk("R7 ecc cfg", 32'h94);
        reg_wr(32'h98, 32'hFFFF_FFFF); reg_chk("R8 ecc status", 32'h98);
        check("R8 irq high", {31'd0, ecc_irq}, 32'd1);
        reg_wr(32'h98, 32'h000F_0FFF);
        check("R8 irq low", {31'd0, ecc_irq}, 32'd0);
        // random phase
        for (int it = 0; it < 400; it++) begin
            off = pick_off($urandom);
            v = $urandom;
            if (off == 32'h20 && ($urandom % 3) != 0) v[31] = 1'b1;
            reg_wr(off, v);
            reg_chk("R1 R3 R7 R9 random readback", pick_off($urandom));
            check("R8 random irq", {31'd0, ecc_irq}, {31'd0, m_estat != 0});
            a = $urandom;
            if ($urandom % 4 != 0) a[31:23] = m_bank[$urandom % 4][31:23];
            hit_chk("R10 R11 random probe", a);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule